// File: doc/BRIEF.md
# Memory Test-Port Data Register Set

This block holds the data-register side of a boundary-scan test port for a memory device. It contains a 3-bit instruction register, a 1-bit bypass register, a 32-bit identification register and a boundary chain of configurable length. Some cells of that chain are fixed placeholders. A separate TAP state machine supplies level strobes for Capture, Shift and Update in both the IR and the DR paths. Each strobe is sampled on the rising edge of TCK. The block decodes the held instruction and routes the chosen register between TDI and TDO.

The boundary chain has a parallel update latch, which is brought out for the pad ring. Two outputs control the pads: one tells them to drive the latch contents (test-drive mode), and one forces every output to high impedance (isolated sampling mode). TDO is re-timed on the falling edge of TCK, and its enable is high only while a shift is in progress. Reset is synchronous and active high.

Top module: `memscan_tdr`

## Requirements
- R1: A reset clears the boundary update latch, deasserts `tdo_en`, `ext_drive` and `force_hiz`, and loads the identification instruction (code 001) into the instruction register. A DR scan that follows directly therefore returns the identification word.
- R2: On Capture-IR the instruction shift stage loads 001. Shift-IR moves TDI in at bit 2 and presents bit 0 on TDO first. The held instruction changes only on Update-IR.
- R3: Instruction codes select these registers: 000 test-drive selects the boundary chain; 001 selects identification; 010 isolated-sample selects the boundary chain; 100 sample/preload selects the boundary chain; 111 selects bypass. Every other code acts as bypass.
- R4: The bypass register captures 0 on Capture-DR. During Shift-DR it places a one-cycle delay between TDI and TDO.
- R5: When identification is selected, Capture-DR loads the word {DIE_REV[3:0], 16'h0908 (wide I/O) or 16'h090A (narrow I/O), 12'h1B3}. With the defaults this is 32'h309081B3. The word shifts out bit 0 first.
- R6: When the boundary chain is selected, Capture-DR loads each cell from its `pin_in` bit. Cells marked in HOLD_MASK (default bits 0, 4 and 11) always capture 1.
- R7: In Shift-DR the boundary chain shifts toward bit 0. Bit 0 is presented on TDO first, and TDI enters at the top cell.
- R8: Update-DR copies the boundary chain into `bsr_par` only while a boundary-chain instruction is held. Under any other instruction, Update-DR leaves `bsr_par` unchanged.
- R9: `ext_drive` is high exactly while code 000 is held. `force_hiz` is high exactly while code 010 is held.
- R10: `tdo` and `tdo_en` change on the falling edge of TCK. `tdo_en` is high only during Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| tdi | input | 1 | Serial test data in |
| capture_ir | input | 1 | Capture-IR state strobe |
| shift_ir | input | 1 | Shift-IR state strobe |
| update_ir | input | 1 | Update-IR state strobe |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| pin_in | input | BSR_LEN | Pin levels observed by the boundary chain |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_en | output | 1 | TDO driver enable |
| bsr_par | output | BSR_LEN | Boundary update latch, the values driven onto pads in test-drive mode |
| ext_drive | output | 1 | Pads take their values from bsr_par |
| force_hiz | output | 1 | All device outputs forced to high impedance |

## Verification
A held instruction that is wrong shows up on the first Update-IR after the fault. `ext_drive` or `force_hiz` take the wrong level in that same cycle, and the next DR scan returns the wrong register, for example bypass zeros where the identification word was expected. A corrupt shift stage or a wrong capture value reaches TDO bit for bit during the following Shift-DR. The first wrong bit appears on the falling edge after the capture cycle. An update latch that loads when it should hold becomes visible on `bsr_par` one rising edge after Update-DR.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [2:0] {
    INS_EXTEST  = 3'b000,
    INS_IDCODE  = 3'b001,
    INS_SAMPLEZ = 3'b010,
    INS_PRELOAD = 3'b100,
    INS_BYPASS  = 3'b111
  } ins_e;

  typedef enum logic [1:0] {
    DR_BYP = 2'd0,
    DR_ID  = 2'd1,
    DR_BSR = 2'd2
  } dr_sel_e;

  // Map the held instruction onto the data register it routes
  function automatic dr_sel_e pick_dr(input logic [2:0] code);
    dr_sel_e sel;
    case (code)
      INS_EXTEST, INS_SAMPLEZ, INS_PRELOAD: sel = DR_BSR;
      INS_IDCODE:                           sel = DR_ID;
      default:                              sel = DR_BYP;
    endcase
    return sel;
  endfunction

  // Constant identification word: revision, I/O-width code, fixed low field
  function automatic logic [31:0] id_word(input logic [3:0] rev, input logic wide);
    logic [15:0] mid;
    mid = wide ? 16'h0908 : 16'h090A;
    return {rev, mid, 12'h1B3};
  endfunction

endpackage

// File: rtl/scan_ir.sv
module scan_ir #(
  parameter int unsigned        IR_W        = 3,
  parameter logic [IR_W-1:0]    CAPTURE_PAT = 3'b001,
  parameter logic [IR_W-1:0]    RESET_CODE  = 3'b001
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_cur
);

  logic [IR_W-1:0] sh_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      sh_q <= CAPTURE_PAT;
    end else if (capture) begin
      sh_q <= CAPTURE_PAT;
    end else if (shift) begin
      sh_q <= {tdi, sh_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_cur <= RESET_CODE;
    end else if (update) begin
      ir_cur <= sh_q;
    end
  end

  assign ir_lsb = sh_q[0];

  p_reset_code_r1: assert property (@(posedge tck) rst |=> ir_cur == RESET_CODE);

  p_ir_hold_r2: assert property (@(posedge tck) disable iff (rst)
    !update |=> $stable(ir_cur));

  p_ir_shift_r2: assert property (@(posedge tck) disable iff (rst)
    (shift && !capture) |=> sh_q[IR_W-2:0] == $past(sh_q[IR_W-1:1]));

endmodule

// File: rtl/scan_idbyp.sv
module scan_idbyp #(
  parameter int unsigned      ID_W   = 32,
  parameter logic [ID_W-1:0]  ID_VAL = '0
) (
  input  logic tck,
  input  logic rst,
  input  logic tdi,
  input  logic capture,
  input  logic shift,
  input  logic sel_id,
  input  logic sel_byp,
  output logic id_lsb,
  output logic byp_q
);

  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck) begin
    if (rst) begin
      id_sr <= '0;
    end else if (sel_id && capture) begin
      id_sr <= ID_VAL;
    end else if (sel_id && shift) begin
      id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
    end else if (sel_byp && capture) begin
      byp_q <= 1'b0;
    end else if (sel_byp && shift) begin
      byp_q <= tdi;
    end
  end

  assign id_lsb = id_sr[0];

  p_byp_zero_r4: assert property (@(posedge tck) disable iff (rst)
    (capture && sel_byp) |=> byp_q == 1'b0);

  p_id_load_r5: assert property (@(posedge tck) disable iff (rst)
    (capture && sel_id) |=> id_sr == ID_VAL);

  p_id_idle_r5: assert property (@(posedge tck) disable iff (rst)
    !sel_id |=> $stable(id_sr));

endmodule

// File: rtl/scan_bsr.sv
module scan_bsr #(
  parameter int unsigned          BSR_LEN   = 20,
  parameter logic [BSR_LEN-1:0]   HOLD_MASK = '0
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tdi,
  input  logic               capture,
  input  logic               shift,
  input  logic               update,
  input  logic               sel,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               cell_lsb,
  output logic [BSR_LEN-1:0] upd_q
);

  logic [BSR_LEN-1:0] cells;
  logic [BSR_LEN-1:0] cap_val;
  logic [BSR_LEN-1:0] shin;

  // placeholder positions read as 1 whatever the pin does
  assign cap_val = pin_in | HOLD_MASK;
  assign shin    = {tdi, cells[BSR_LEN-1:1]};

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    always_ff @(posedge tck) begin
      if (rst) begin
        cells[i] <= 1'b0;
      end else if (sel && capture) begin
        cells[i] <= cap_val[i];
      end else if (sel && shift) begin
        cells[i] <= shin[i];
      end
    end

    always_ff @(posedge tck) begin
      if (rst) begin
        upd_q[i] <= 1'b0;
      end else if (sel && update) begin
        upd_q[i] <= cells[i];
      end
    end
  end

  assign cell_lsb = cells[0];

  p_placeholder_one_r6: assert property (@(posedge tck) disable iff (rst)
    (sel && capture) |=> (cells & HOLD_MASK) == HOLD_MASK);

  p_shift_lsb_r7: assert property (@(posedge tck) disable iff (rst)
    (sel && shift && !capture) |=> cells[BSR_LEN-2:0] == $past(cells[BSR_LEN-1:1]));

  p_update_hold_r8: assert property (@(posedge tck) disable iff (rst)
    !(sel && update) |=> $stable(upd_q));

endmodule

// File: rtl/memscan_tdr.sv
module memscan_tdr
  import scan_pkg::*;
#(
  parameter int unsigned        BSR_LEN   = 20,
  parameter logic [BSR_LEN-1:0] HOLD_MASK = 20'h00811,
  parameter logic [3:0]         DIE_REV   = 4'h3,
  parameter bit                 WIDE_IO   = 1'b1
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tdi,
  input  logic               capture_ir,
  input  logic               shift_ir,
  input  logic               update_ir,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               tdo,
  output logic               tdo_en,
  output logic [BSR_LEN-1:0] bsr_par,
  output logic               ext_drive,
  output logic               force_hiz
);

  localparam int unsigned IR_W   = 3;
  localparam int unsigned ID_W   = 32;
  localparam logic [ID_W-1:0] ID_VAL = id_word(DIE_REV, WIDE_IO);

  logic [IR_W-1:0] ir_cur;
  logic            ir_lsb;
  logic            id_lsb;
  logic            byp_q;
  logic            bsr_lsb;
  logic            dr_lsb;
  dr_sel_e         dr_sel;
  logic            sel_id, sel_byp, sel_bsr;

  scan_ir #(
    .IR_W       (IR_W),
    .CAPTURE_PAT(3'b001),
    .RESET_CODE (INS_IDCODE)
  ) u_ir (
    .tck    (tck),
    .rst    (rst),
    .tdi    (tdi),
    .capture(capture_ir),
    .shift  (shift_ir),
    .update (update_ir),
    .ir_lsb (ir_lsb),
    .ir_cur (ir_cur)
  );

  assign dr_sel  = pick_dr(ir_cur);
  assign sel_id  = (dr_sel == DR_ID);
  assign sel_byp = (dr_sel == DR_BYP);
  assign sel_bsr = (dr_sel == DR_BSR);

  scan_idbyp #(
    .ID_W  (ID_W),
    .ID_VAL(ID_VAL)
  ) u_idbyp (
    .tck    (tck),
    .rst    (rst),
    .tdi    (tdi),
    .capture(capture_dr),
    .shift  (shift_dr),
    .sel_id (sel_id),
    .sel_byp(sel_byp),
    .id_lsb (id_lsb),
    .byp_q  (byp_q)
  );

  scan_bsr #(
    .BSR_LEN  (BSR_LEN),
    .HOLD_MASK(HOLD_MASK)
  ) u_bsr (
    .tck     (tck),
    .rst     (rst),
    .tdi     (tdi),
    .capture (capture_dr),
    .shift   (shift_dr),
    .update  (update_dr),
    .sel     (sel_bsr),
    .pin_in  (pin_in),
    .cell_lsb(bsr_lsb),
    .upd_q   (bsr_par)
  );

  always_comb begin
    case (dr_sel)
      DR_ID:   dr_lsb = id_lsb;
      DR_BSR:  dr_lsb = bsr_lsb;
      default: dr_lsb = byp_q;
    endcase
  end

  // serial output re-timed half a cycle after the shifting edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= shift_ir || shift_dr;
      if (shift_ir) begin
        tdo <= ir_lsb;
      end else if (shift_dr) begin
        tdo <= dr_lsb;
      end
    end
  end

  assign ext_drive = (ir_cur == INS_EXTEST);
  assign force_hiz = (ir_cur == INS_SAMPLEZ);

  p_drive_update_r9: assert property (@(posedge tck) disable iff (rst)
    !update_ir |=> $stable(ext_drive) && $stable(force_hiz));

endmodule

// File: tb/test_memscan_tdr.sv
module test_memscan_tdr;

  localparam int BSR_LEN = 20;
  localparam logic [BSR_LEN-1:0] MASK = 20'h00811;
  localparam logic [31:0] ID_EXP = {4'h3, 16'h0908, 12'h1B3};

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tdi = 1'b0;
  logic capture_ir = 0, shift_ir = 0, update_ir = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic [BSR_LEN-1:0] pin_in = '0;
  logic tdo, tdo_en, ext_drive, force_hiz;
  logic [BSR_LEN-1:0] bsr_par;

  int total = 0;
  int bad = 0;

  always #2 tck = ~tck;

  memscan_tdr i_memscan_tdr (
    .tck(tck), .rst(rst), .tdi(tdi),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .pin_in(pin_in), .tdo(tdo), .tdo_en(tdo_en), .bsr_par(bsr_par),
    .ext_drive(ext_drive), .force_hiz(force_hiz)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one TCK cycle: entered at posedge+1, sample after the falling edge
  task automatic step(input logic ti, output logic to, output logic toe);
    tdi = ti;
    #2;
    to  = tdo;
    toe = tdo_en;
    @(posedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [2:0] code, input bit upd, output logic [2:0] cap);
    logic o, e;
    capture_ir = 1;
    step(1'b0, o, e);
    capture_ir = 0;
    shift_ir = 1;
    for (int i = 0; i < 3; i++) begin
      step(code[i], o, e);
      cap[i] = o;
    end
    shift_ir = 0;
    if (upd) begin
      update_ir = 1;
      step(1'b0, o, e);
      update_ir = 0;
    end
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input bit upd,
                         output logic [63:0] dout, output bit en_ok);
    logic o, e;
    dout  = '0;
    en_ok = 1;
    capture_dr = 1;
    step(1'b0, o, e);
    if (e !== 1'b0) en_ok = 0;
    capture_dr = 0;
    shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      step(din[i], o, e);
      dout[i] = o;
      if (e !== 1'b1) en_ok = 0;
    end
    shift_dr = 0;
    if (upd) begin
      update_dr = 1;
      step(1'b0, o, e);
      update_dr = 0;
    end
  endtask

  task automatic t_reset;
    logic [63:0] d;
    bit ok;
    chk("R1 tdo_en", tdo_en, 0);
    chk("R1 ext_drive", ext_drive, 0);
    chk("R1 force_hiz", force_hiz, 0);
    chk("R1 bsr_par", bsr_par, 0);
    scan_dr(32, 64'h0, 0, d, ok);
    chk("R1 idcode after reset", d[31:0], ID_EXP);
  endtask

  task automatic t_idcode;
    logic [63:0] d;
    bit ok;
    scan_dr(32, 64'hFFFF_FFFF, 0, d, ok);
    chk("R5 id word lsb first", d[31:0], ID_EXP);
    chk("R10 tdo_en only in shift", ok, 1);
  endtask

  task automatic t_ir_capture;
    logic [2:0] cap;
    load_ir(3'b111, 1, cap);
    chk("R2 capture pattern", cap, 3'b001);
    chk("R9 bypass no drive", {ext_drive, force_hiz}, 2'b00);
  endtask

  task automatic t_bypass(input logic [2:0] code, input string tag);
    logic [63:0] d;
    logic [2:0] cap;
    bit ok;
    load_ir(code, 1, cap);
    scan_dr(12, 64'hB5D, 0, d, ok);
    chk(tag, d[11:0], {12'hB5D << 1} & 12'hFFF);
  endtask

  task automatic t_preload;
    logic [63:0] d;
    logic [2:0] cap;
    bit ok;
    load_ir(3'b100, 1, cap);
    chk("R9 preload flags", {ext_drive, force_hiz}, 2'b00);
    pin_in = 20'hA52C2;
    scan_dr(BSR_LEN, 64'h3C96A, 1, d, ok);
    chk("R6 capture pins and placeholders", d[BSR_LEN-1:0], 20'hA52C2 | MASK);
    chk("R7 R8 shifted pattern updated", bsr_par, 20'h3C96A);
  endtask

  task automatic t_extest;
    logic [63:0] d;
    logic [2:0] cap;
    bit ok;
    load_ir(3'b000, 1, cap);
    chk("R9 extest drive", {ext_drive, force_hiz}, 2'b10);
    chk("R8 latch kept over ir load", bsr_par, 20'h3C96A);
    pin_in = 20'h00000;
    scan_dr(BSR_LEN, 64'h5A0F1, 1, d, ok);
    chk("R6 placeholders only", d[BSR_LEN-1:0], MASK);
    chk("R8 extest update", bsr_par, 20'h5A0F1);
  endtask

  task automatic t_samplez;
    logic [63:0] d;
    logic [2:0] cap;
    bit ok;
    load_ir(3'b010, 1, cap);
    chk("R9 samplez hiz", {ext_drive, force_hiz}, 2'b01);
    pin_in = 20'hFFFFF;
    scan_dr(BSR_LEN, 64'h12345, 1, d, ok);
    chk("R6 all pins high", d[BSR_LEN-1:0], 20'hFFFFF);
    chk("R8 samplez update", bsr_par, 20'h12345);
  endtask

  task automatic t_no_update;
    logic [63:0] d;
    logic [2:0] cap;
    bit ok;
    load_ir(3'b111, 1, cap);
    scan_dr(BSR_LEN, 64'hFFFFF, 1, d, ok);
    chk("R8 update ignored under bypass", bsr_par, 20'h12345);
    load_ir(3'b000, 0, cap);
    chk("R2 no change without update-ir", ext_drive, 0);
    scan_dr(4, 64'h0, 0, d, ok);
    chk("R2 bypass still held", d[3:0], 4'h0);
  endtask

  task automatic t_tdo_edge;
    logic o, e;
    logic [2:0] cap;
    load_ir(3'b001, 1, cap);
    capture_dr = 1;
    step(1'b0, o, e);
    capture_dr = 0;
    shift_dr = 1;
    tdi = 1'b0;
    #0;
    chk("R10 enable waits for falling edge", tdo_en, 0);
    @(negedge tck);
    #0.5;
    chk("R10 enable after falling edge", tdo_en, 1);
    chk("R10 first bit at falling edge", tdo, ID_EXP[0]);
    @(posedge tck);
    #1;
    chk("R10 tdo holds across rising edge", tdo, ID_EXP[0]);
    #1.5;
    chk("R10 second bit", tdo, ID_EXP[1]);
    @(posedge tck);
    #1;
    shift_dr = 0;
    step(1'b0, o, e);
    chk("R10 enable drops after shift", e, 0);
  endtask

  task automatic t_midreset;
    logic [63:0] d;
    logic [2:0] cap;
    bit ok;
    load_ir(3'b000, 1, cap);
    rst = 1;
    @(posedge tck);
    #1;
    rst = 0;
    chk("R1 reset clears latch", bsr_par, 0);
    chk("R1 reset clears drive", ext_drive, 0);
    scan_dr(32, 64'h0, 0, d, ok);
    chk("R1 idcode after mid reset", d[31:0], ID_EXP);
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge tck);
    #1;
    rst = 0;
    t_reset();
    t_idcode();
    t_ir_capture();
    t_bypass(3'b111, "R4 bypass delay code 111");
    t_bypass(3'b101, "R3 unused code 101 acts as bypass");
    t_bypass(3'b011, "R3 unused code 011 acts as bypass");
    t_preload();
    t_extest();
    t_samplez();
    t_no_update();
    t_tdo_edge();
    t_midreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule